// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Breakpoint Freeze

This block runs a successive-approximation conversion over a small bank of channels. For each channel it opens a sampling window, then resolves the value one bit at a time, most significant bit first. It does this by presenting a trial code to an abstract DAC and reading back a single comparator bit. The timing comes from a conversion clock, which is derived from the system clock through a programmable divider. Each finished value is written to that channel's result register, and the channel's valid flag is raised. After the last channel the sequence stops.

Software programs a timing register that holds the resolution, the sample-window length and the divider, and a start register that holds the breakpoint behaviour. A write to either register aborts whatever is in flight, clears every valid flag and starts a fresh sequence at channel 0 with the new settings. A debug-active input, together with the freeze mode, decides what happens during a breakpoint: the sequencer keeps running, finishes the current conversion and then waits, or stops on the spot. When the breakpoint ends, it carries on from the exact point where it stopped.

The control state machine has four states:
- `ST_IDLE`: nothing running.
- `ST_SAMPLE`: sampling window open, with `sample_en` high.
- `ST_CONVERT`: one bit decided per conversion-clock tick.
- `ST_STORE`: a single system cycle in which the result is written.

The transitions are:
- idle→sample on any register write.
- sample→convert on the tick that closes the window.
- convert→store on the tick that resolves the last bit.
- store→sample when more channels remain.
- store→idle after the last channel.
- any state→sample on a register write.

While a freeze holds, the state machine stays in its current state.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the timing register reads 0x01 and the freeze mode is 00. The sequencer is idle: `sample_en`=0, `dac_code`=0, `chan_sel`=0, all `done_flags`=0. No conversion begins until a register write.
- R2: A write with `wr_sel`=0 loads the timing register: bit 7 selects 10-bit resolution (1) or 8-bit (0), bits 6:5 select the sample length, and bits 4:0 hold the divider value PRS. A write with `wr_sel`=1 loads the freeze mode from bits 7:6. Either write aborts the current activity in the same cycle, clears all valid flags, and restarts at channel 0 in the sampling state with the new settings.
- R3: One conversion-clock tick occurs every 2×(PRS+1) system cycles, counted from the start of each channel.
- R4: The sampling window lasts 2, 4, 8 or 16 ticks for sample-select values 0 to 3. `sample_en` is high for exactly that window, and `dac_code` is 0 throughout it.
- R5: Conversion takes one tick per result bit, most significant bit first. Each trial bit is kept when `cmp_hi`=1 and dropped otherwise. In 10-bit mode the stored result equals the analog code.
- R6: In 8-bit mode only bits 9:2 are resolved. The result is left-justified in the 10-bit field, with bits 1:0 equal to 0.
- R7: One system cycle after the last bit is resolved, the result is written and the channel's flag is set. A channel therefore takes (N+B)×2×(PRS+1)+1 system cycles, where N is the window length in ticks and B is 8 or 10. Channels run in ascending order, and the sequencer goes idle after the last one.
- R8: With freeze mode 00, or the reserved value 01, `dbg_active` has no effect on timing or results.
- R9: With freeze mode 11 and `dbg_active`=1, every output holds its value. After release, the sequence completes exactly as many cycles late as the hold lasted.
- R10: With freeze mode 10 and `dbg_active`=1, the conversion in progress completes and stores. The sequencer then waits at the first cycle of the next channel's sampling window, with `sample_en`=1 and `chan_sel` already advanced.
- R11: A register write during a freeze still aborts and restarts the sequence. The sequencer then remains held for as long as the freeze condition lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = timing register, 1 = start register |
| wr_data | input | 8 | Write data |
| dbg_active | input | 1 | Breakpoint in progress |
| cmp_hi | input | 1 | Comparator: analog input at or above `dac_code` |
| dac_code | output | 10 | Trial code for the DAC |
| sample_en | output | 1 | Sampling window open |
| chan_sel | output | CH_W | Channel being converted |
| results | output | NCH×10 | Result registers, channel k at bits [10k+9:10k] |
| done_flags | output | NCH | Per-channel valid flags |

## Verification
A wrong divider count or window length moves the instant a valid flag rises, so every flag rise is checked against its exact cycle. A single-cycle slip shows up within one channel period. A wrong trial-bit decision shows up in the stored value as soon as that channel's flag rises, and in 8-bit mode nonzero low bits on `dac_code` would appear in the first conversion cycle. A freeze that leaks shows up as movement on `dac_code`, `sample_en` or `chan_sel` while the hold is asserted. A resume that does not restore the exact state shows up as a flag arriving earlier or later than the hold length predicts.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int RES_W = 10;
    localparam int PRS_W = 5;
    localparam int SMP_CW = 5;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SAMPLE  = 2'd1,
        ST_CONVERT = 2'd2,
        ST_STORE   = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        FRZ_RUN    = 2'b00,
        FRZ_RSVD   = 2'b01,
        FRZ_FINISH = 2'b10,
        FRZ_NOW    = 2'b11
    } frz_mode_e;

    typedef struct packed {
        logic             res10;
        logic [1:0]       smp;
        logic [PRS_W-1:0] prs;
    } timing_reg_t;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div
    import adc_seq_pkg::*;
#(
    parameter int DIV_W = PRS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [DIV_W-1:0] prs,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // last count of a 2*(prs+1) period
    assign limit = {prs, 1'b1};
    assign tick  = run && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc_sar_path.sv
module adc_sar_path
    import adc_seq_pkg::*;
#(
    parameter int W = RES_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic         step,
    input  logic         res_full,
    input  logic         cmp_hi,
    output logic [W-1:0] trial,
    output logic         last
);
    localparam int LOW_IDX = W - 8;

    logic [W-1:0] bit_q;
    logic [W-1:0] kept;
    logic [W-1:0] trial_nx;

    assign last = step && (res_full ? bit_q[0] : bit_q[LOW_IDX]);

    always_comb begin
        kept     = cmp_hi ? trial : (trial & ~bit_q);
        trial_nx = last ? kept : (kept | (bit_q >> 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trial <= '0;
            bit_q <= '0;
        end else if (clr) begin
            trial <= '0;
            bit_q <= '0;
        end else if (load) begin
            trial <= {1'b1, {(W-1){1'b0}}};
            bit_q <= {1'b1, {(W-1){1'b0}}};
        end else if (step) begin
            trial <= trial_nx;
            bit_q <= last ? '0 : (bit_q >> 1);
        end
    end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adc_seq_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int CH_W = 2,
    parameter int W    = RES_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_flags,
    input  logic             wr,
    input  logic [CH_W-1:0]  wr_ch,
    input  logic [W-1:0]     wr_data,
    output logic [NCH*W-1:0] results,
    output logic [NCH-1:0]   flags
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [W-1:0] val_q;
        logic         vld_q;
        logic         hit;

        assign hit = wr && (wr_ch == CH_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= '0;
                vld_q <= 1'b0;
            end else begin
                if (hit) val_q <= wr_data;
                if (clr_flags)  vld_q <= 1'b0;
                else if (hit)   vld_q <= 1'b1;
            end
        end

        assign results[g*W +: W] = val_q;
        assign flags[g]          = vld_q;
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [7:0]           wr_data,
    input  logic                 dbg_active,
    input  logic                 cmp_hi,
    output logic [RES_W-1:0]     dac_code,
    output logic                 sample_en,
    output logic [CH_W-1:0]      chan_sel,
    output logic [NCH*RES_W-1:0] results,
    output logic [NCH-1:0]       done_flags
);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NCH - 1);

    timing_reg_t       ctrl_q;
    frz_mode_e         frz_q;
    seq_state_e        state_q, state_nx;
    logic [SMP_CW-1:0] smp_cnt_q;
    logic [SMP_CW-1:0] smp_lim;
    logic [CH_W-1:0]   chan_q;
    logic              busy_q;

    logic restart, hold, run, tick;
    logic div_clr, sar_clr, sar_load, sar_step, sar_last;
    logic store_wr;

    assign restart = wr_en;
    assign smp_lim = (SMP_CW'(2) << ctrl_q.smp) - SMP_CW'(1);

    // breakpoint hold decision
    always_comb begin
        hold = 1'b0;
        if (dbg_active) begin
            unique case (frz_q)
                FRZ_NOW:    hold = 1'b1;
                FRZ_FINISH: hold = (state_q == ST_SAMPLE) && !busy_q;
                FRZ_RUN,
                FRZ_RSVD:   hold = 1'b0;
            endcase
        end
    end

    assign run = !hold && ((state_q == ST_SAMPLE) || (state_q == ST_CONVERT));

    // register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= timing_reg_t'(8'h01);
            frz_q  <= FRZ_RUN;
        end else if (wr_en) begin
            if (wr_sel) frz_q  <= frz_mode_e'(wr_data[7:6]);
            else        ctrl_q <= timing_reg_t'(wr_data);
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        if (restart) begin
            state_nx = ST_SAMPLE;
        end else if (!hold) begin
            unique case (state_q)
                ST_IDLE:    state_nx = ST_IDLE;
                ST_SAMPLE:  if (tick && smp_cnt_q == smp_lim) state_nx = ST_CONVERT;
                ST_CONVERT: if (sar_last) state_nx = ST_STORE;
                ST_STORE:   state_nx = (chan_q == LAST_CH) ? ST_IDLE : ST_SAMPLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // control outputs
    always_comb begin
        sample_en = 1'b0;
        sar_load  = 1'b0;
        sar_step  = 1'b0;
        store_wr  = 1'b0;
        sar_clr   = restart;
        div_clr   = restart;
        unique case (state_q)
            ST_IDLE: begin
                div_clr = 1'b1;
            end
            ST_SAMPLE: begin
                sample_en = 1'b1;
                sar_load  = !restart && tick && (smp_cnt_q == smp_lim);
            end
            ST_CONVERT: begin
                sar_step = !restart && tick;
            end
            ST_STORE: begin
                div_clr  = 1'b1;
                store_wr = !restart && !hold;
                sar_clr  = restart || !hold;
            end
        endcase
    end

    // sample counter, channel pointer, busy marker
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_cnt_q <= '0;
            chan_q    <= '0;
            busy_q    <= 1'b0;
        end else if (restart) begin
            smp_cnt_q <= '0;
            chan_q    <= '0;
            busy_q    <= 1'b0;
        end else if (!hold) begin
            unique case (state_q)
                ST_IDLE: begin
                    busy_q <= 1'b0;
                end
                ST_SAMPLE: begin
                    busy_q <= 1'b1;
                    if (tick) smp_cnt_q <= (smp_cnt_q == smp_lim) ? '0 : smp_cnt_q + 1'b1;
                end
                ST_CONVERT: begin
                    busy_q <= 1'b1;
                end
                ST_STORE: begin
                    busy_q    <= 1'b0;
                    smp_cnt_q <= '0;
                    if (chan_q != LAST_CH) chan_q <= chan_q + 1'b1;
                end
            endcase
        end
    end

    adc_clk_div #(.DIV_W(PRS_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (div_clr),
        .run   (run),
        .prs   (ctrl_q.prs),
        .tick  (tick)
    );

    adc_sar_path #(.W(RES_W)) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sar_clr),
        .load     (sar_load),
        .step     (sar_step),
        .res_full (ctrl_q.res10),
        .cmp_hi   (cmp_hi),
        .trial    (dac_code),
        .last     (sar_last)
    );

    adc_result_bank #(.NCH(NCH), .CH_W(CH_W), .W(RES_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_flags (restart),
        .wr        (store_wr),
        .wr_ch     (chan_q),
        .wr_data   (dac_code),
        .results   (results),
        .flags     (done_flags)
    );

    assign chan_sel = chan_q;
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker
    import adc_seq_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             dbg_active,
    input logic [1:0]       frz_q,
    input logic             res10,
    input logic [1:0]       state_q,
    input logic             busy_q,
    input logic [RES_W-1:0] dac_code,
    input logic             sample_en,
    input logic [CH_W-1:0]  chan_sel,
    input logic [NCH-1:0]   done_flags
);
    a_r2_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (done_flags == '0) && (chan_sel == '0) && sample_en);

    a_r4_window_no_trial: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> (dac_code == '0));

    a_r6_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !res10 |-> (dac_code[1:0] == 2'b00));

    a_r7_one_flag_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_flags & ~$past(done_flags)));

    a_r9_freeze_holds_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_active && frz_q == 2'b11 && !wr_en) |=>
            ($stable(dac_code) && $stable(sample_en) && $stable(chan_sel) && $stable(done_flags)));

    a_r10_waits_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_active && frz_q == 2'b10 && state_q == 2'(ST_SAMPLE) && !busy_q && !wr_en) |=>
            (sample_en && $stable(chan_sel) && $stable(done_flags)));
endmodule

bind adc_seq_ctrl adc_seq_checker #(.NCH(NCH), .CH_W(CH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .dbg_active (dbg_active),
    .frz_q      (frz_q),
    .res10      (ctrl_q.res10),
    .state_q    (state_q),
    .busy_q     (busy_q),
    .dac_code   (dac_code),
    .sample_en  (sample_en),
    .chan_sel   (chan_sel),
    .done_flags (done_flags)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
    localparam int NCH  = 4;
    localparam int CH_W = 2;
    localparam int W    = 10;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 wr_en = 1'b0;
    logic                 wr_sel = 1'b0;
    logic [7:0]           wr_data = '0;
    logic                 dbg_active = 1'b0;
    logic                 cmp_hi;
    logic [W-1:0]         dac_code;
    logic                 sample_en;
    logic [CH_W-1:0]      chan_sel;
    logic [NCH*W-1:0]     results;
    logic [NCH-1:0]       done_flags;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    function automatic logic [W-1:0] vin(input logic [CH_W-1:0] ch);
        case (ch)
            2'd0:    return 10'h2A7;
            2'd1:    return 10'h3FF;
            2'd2:    return 10'h000;
            default: return 10'h155;
        endcase
    endfunction

    assign cmp_hi = (vin(chan_sel) >= dac_code);

    adc_seq_ctrl #(.NCH(NCH), .CH_W(CH_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .dbg_active (dbg_active),
        .cmp_hi     (cmp_hi),
        .dac_code   (dac_code),
        .sample_en  (sample_en),
        .chan_sel   (chan_sel),
        .results    (results),
        .done_flags (done_flags)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // drive at a falling edge; returns at the falling edge after the capturing edge
    task automatic reg_wr(input logic sel, input logic [7:0] data);
        wr_sel  = sel;
        wr_data = data;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // check the flag of channel k rises exactly after 'per' cycles
    task automatic flag_at(input string req, input int k, input int per);
        wait_n(per - 1);
        chk(req, 32'(done_flags[k]), 32'd0);
        wait_n(1);
        chk(req, 32'(done_flags[k]), 32'd1);
    endtask

    task automatic check_results(input string req, input logic [W-1:0] mask);
        for (int k = 0; k < NCH; k++)
            chk(req, 32'(results[k*W +: W]), 32'(vin(CH_W'(k)) & mask));
    endtask

    task automatic t_reset;
        chk("R1 flags", 32'(done_flags), 32'd0);
        chk("R1 sample_en", 32'(sample_en), 32'd0);
        chk("R1 dac_code", 32'(dac_code), 32'd0);
        wait_n(100);
        chk("R1 still idle", 32'(sample_en), 32'd0);
        chk("R1 chan", 32'(chan_sel), 32'd0);
    endtask

    task automatic t_default;  // 0x01: PRS=1 (4 cycles), N=2, 8-bit -> 41
        reg_wr(1'b1, 8'h00);
        for (int k = 0; k < NCH; k++) flag_at("R3 R7 default period", k, 41);
        check_results("R6 8-bit results", 10'h3FC);
        wait_n(2);
        chk("R7 idle after last", 32'(sample_en), 32'd0);
    endtask

    task automatic t_res10;  // 0xA2: 10-bit, N=4, PRS=2 (6 cycles) -> 85
        reg_wr(1'b0, 8'hA2);
        for (int k = 0; k < NCH; k++) flag_at("R5 R3 10-bit period", k, 85);
        check_results("R5 10-bit results", 10'h3FF);
    endtask

    task automatic t_sample;  // 0xE0: 10-bit, N=16, PRS=0 (2 cycles) -> 53
        reg_wr(1'b0, 8'hE0);
        chk("R4 window opens", 32'(sample_en), 32'd1);
        wait_n(31);
        chk("R4 window last cycle", 32'(sample_en), 32'd1);
        wait_n(1);
        chk("R4 window closed", 32'(sample_en), 32'd0);
        chk("R5 msb trial", 32'(dac_code), 32'h200);
        flag_at("R4 period N=16", 0, 21);
    endtask

    task automatic t_run_modes;
        reg_wr(1'b0, 8'h01);
        dbg_active = 1'b1;
        reg_wr(1'b1, 8'h00);
        flag_at("R8 mode 00 ignores debug", 0, 41);
        reg_wr(1'b1, 8'h40);
        flag_at("R8 mode 01 ignores debug", 0, 41);
        dbg_active = 1'b0;
        wait_n(200);
        check_results("R8 results unchanged", 10'h3FC);
    endtask

    task automatic t_freeze_now;
        logic [W-1:0] snap;
        reg_wr(1'b1, 8'hC0);
        wait_n(20);
        dbg_active = 1'b1;
        snap = dac_code;
        wait_n(150);
        chk("R9 dac frozen", 32'(dac_code), 32'(snap));
        wait_n(150);
        chk("R9 dac frozen late", 32'(dac_code), 32'(snap));
        chk("R9 no flag", 32'(done_flags), 32'd0);
        dbg_active = 1'b0;
        flag_at("R9 delayed by hold", 0, 21);
        chk("R9 result ch0", 32'(results[0 +: W]), 32'(10'h2A7 & 10'h3FC));
        wait_n(200);
    endtask

    task automatic t_freeze_finish;
        reg_wr(1'b1, 8'h80);
        wait_n(20);
        dbg_active = 1'b1;
        flag_at("R10 current finishes", 0, 21);
        wait_n(200);
        chk("R10 waits flags", 32'(done_flags), 32'h1);
        chk("R10 waits chan", 32'(chan_sel), 32'd1);
        chk("R10 waits window", 32'(sample_en), 32'd1);
        chk("R10 waits dac", 32'(dac_code), 32'd0);
        dbg_active = 1'b0;
        flag_at("R10 resumes", 1, 41);
        flag_at("R10 continues", 2, 41);
        flag_at("R10 continues", 3, 41);
        check_results("R10 results", 10'h3FC);
    endtask

    task automatic t_abort;
        reg_wr(1'b1, 8'h00);
        wait_n(49);
        chk("R2 ch0 done before abort", 32'(done_flags[0]), 32'd1);
        reg_wr(1'b0, 8'hA2);
        chk("R2 flags cleared", 32'(done_flags), 32'd0);
        chk("R2 chan reset", 32'(chan_sel), 32'd0);
        chk("R2 restart window", 32'(sample_en), 32'd1);
        flag_at("R2 new settings", 0, 85);
        chk("R2 10-bit value", 32'(results[0 +: W]), 32'h2A7);
        wait_n(300);
    endtask

    task automatic t_write_in_freeze;
        reg_wr(1'b1, 8'hC0);
        wait_n(20);
        dbg_active = 1'b1;
        wait_n(50);
        reg_wr(1'b0, 8'h01);
        chk("R11 restart in freeze chan", 32'(chan_sel), 32'd0);
        chk("R11 restart in freeze dac", 32'(dac_code), 32'd0);
        chk("R11 restart in freeze window", 32'(sample_en), 32'd1);
        wait_n(99);
        chk("R11 still held", 32'(done_flags), 32'd0);
        dbg_active = 1'b0;
        flag_at("R11 resumes after hold", 0, 41);
        dbg_active = 1'b0;
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
        t_reset();
        t_default();
        t_res10();
        t_sample();
        t_run_modes();
        t_freeze_now();
        t_freeze_finish();
        t_abort();
        t_write_in_freeze();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule